// File: doc/BRIEF.md
# Prescaled Bus-Wait Timeout Timer

This block measures how long a watched wait condition stays active, for instance a clock line held low by a slow peer or an engine stalled on a handshake, and raises a timeout when that wait lasts longer than a programmed limit. The time base is the system clock divided by a power of two. A 4-bit select gives the exponent, so a 15-bit limit can span waits of tens of milliseconds without a wide counter.

Software writes one 16-bit control word that carries an enable flag and the limit. The divider exponent comes from a separate select input, which the surrounding register file keeps stable while a wait is being timed. When the count of divided ticks reaches the limit, the block emits a single-cycle pulse. That pulse also sets a sticky status flag, which stays high until the status clear input is asserted. The timer and the prescaler both restart whenever the condition drops, the enable is off, or the control word is rewritten.

Top module: `wait_timeout_timer`

## Requirements
- R1: On `cfg_wr`, bit 15 of `cfg_word` becomes the enable and bits 14:0 become the limit L. After synchronous reset the block is disabled with L = 0, and `expire_pulse` and `tmo_flag` are both low.
- R2: While timing is active, the prescaler produces one tick every 2^N clocks, where N = `div_sel` (0..15). With N = 0 there is a tick on every clock.
- R3: If `hold_active` is high before clock edge 1 and stays high, `expire_pulse` is high in the cycle after edge L*2^N, for L >= 1.
- R4: A limit of 0 behaves like a limit of 1: the pulse follows the first tick.
- R5: The pulse lasts exactly one cycle and fires only once per continuous stretch of the condition.
- R6: Any edge at which `hold_active` is low clears the prescaler and the count, so progress made before the drop is lost.
- R7: When the stored enable is 0, no pulse occurs and the sticky flag stays clear, however long the condition lasts.
- R8: An edge with `cfg_wr` high restarts timing. Counting resumes from zero on the next edge.
- R9: `tmo_flag` goes high the cycle after a pulse and holds until an edge with `sts_clr` high. If a set and a clear arrive on the same edge, the set wins.
- R10: The full range works: L = 0x7FFF with N = 0 expires after 32767 edges, and L = 1 with N = 15 expires after 32768 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_word | input | 16 | Enable (bit 15) and limit (bits 14:0) |
| div_sel | input | 4 | Prescaler exponent N |
| hold_active | input | 1 | Watched wait condition |
| sts_clr | input | 1 | Clears the sticky timeout flag |
| expire_pulse | output | 1 | One-cycle timeout pulse |
| tmo_flag | output | 1 | Sticky timeout status |

## Verification
A table of exponent and limit pairs is run, and the edge at which the first pulse appears is measured exactly. This separates an off-by-one in the tick spacing (a wrong N) from an off-by-one in the limit compare (a wrong L), and it also checks the zero-limit case and both ends of the range. Directed patterns then drop the condition part-way through, rewrite the control word part-way through, and hold the condition long after expiry, which tells a missing clear or restart apart from a pulse that fires again. A final pattern arrives with the enable off and must produce nothing. The sticky flag is checked across a drop of the condition, against an explicit clear, and against a clear that lands on the same edge as a set.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

    localparam int CNT_W  = 15;
    localparam int SEL_W  = 4;
    localparam int PRE_W  = (2 ** SEL_W) - 1;
    localparam int WORD_W = CNT_W + 1;

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] limit;
    } tmo_ctrl_t;

    function automatic tmo_ctrl_t ctrl_unpack(input logic [WORD_W-1:0] w);
        tmo_ctrl_t c;
        c.en    = w[WORD_W-1];
        c.limit = w[CNT_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/tmo_prescaler.sv
module tmo_prescaler #(
    parameter int SEL_W = tmo_pkg::SEL_W,
    parameter int PRE_W = tmo_pkg::PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // low N bits all ones marks the last clock of each 2^N window
    assign mask   = (PRE_W'(1) << sel_i) - PRE_W'(1);
    assign tick_o = run_i && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick_o && sel_i != '0 && $stable(sel_i)) |=> !tick_o); // R2

endmodule

// File: rtl/tmo_counter.sv
module tmo_counter #(
    parameter int CNT_W = tmo_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             pulse_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             fired_q;
    logic [CNT_W:0]   cnt_next;
    logic             reached;

    assign cnt_next = {1'b0, cnt_q} + (CNT_W+1)'(1);
    assign reached  = tick_i && !fired_q && (cnt_next >= {1'b0, limit_i});

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= reached;
            if (reached) begin
                fired_q <= 1'b1;
            end
            if (tick_i && !fired_q) begin
                cnt_q <= cnt_next[CNT_W-1:0];
            end
        end
    end

    AST_CLEAR_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (cnt_q == '0 && !pulse_o)); // R6
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (cnt_q <= limit_i) || (cnt_q == CNT_W'(1))); // R10

endmodule

// File: rtl/tmo_sticky.sv
module tmo_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

    AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o); // R9
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o); // R9

endmodule

// File: rtl/wait_timeout_timer.sv
module wait_timeout_timer
    import tmo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic              hold_active,
    input  logic              sts_clr,
    output logic              expire_pulse,
    output logic              tmo_flag
);

    tmo_ctrl_t ctrl_q;
    logic      run;
    logic      tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (cfg_wr) begin
            ctrl_q <= ctrl_unpack(cfg_word);
        end
    end

    // a write edge counts as idle, so timing restarts from zero
    assign run = ctrl_q.en && hold_active && !cfg_wr;

    tmo_prescaler #(.SEL_W(SEL_W), .PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .sel_i  (div_sel),
        .tick_o (tick)
    );

    tmo_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run_i   (run),
        .tick_i  (tick),
        .limit_i (ctrl_q.limit),
        .pulse_o (expire_pulse)
    );

    tmo_sticky u_sts (
        .clk    (clk),
        .rst    (rst),
        .set_i  (expire_pulse),
        .clr_i  (sts_clr),
        .flag_o (tmo_flag)
    );

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.en |=> !expire_pulse); // R7
    AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> !expire_pulse); // R8

endmodule

// File: tb/wait_timeout_timer_tb.sv
module wait_timeout_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_word = '0;
    logic [3:0]  div_sel = '0;
    logic        hold_active = 1'b0;
    logic        sts_clr = 1'b0;
    logic        expire_pulse;
    logic        tmo_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wait_timeout_timer u_dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_wr       (cfg_wr),
        .cfg_word     (cfg_word),
        .div_sel      (div_sel),
        .hold_active  (hold_active),
        .sts_clr      (sts_clr),
        .expire_pulse (expire_pulse),
        .tmo_flag     (tmo_flag)
    );

    // exponent, limit, expected edge of first pulse
    localparam int NV = 8;
    localparam int VN [NV] = '{0, 0, 1, 2, 3, 4, 0, 2};
    localparam int VL [NV] = '{1, 5, 3, 4, 7, 2, 0, 0};
    localparam int VE [NV] = '{1, 5, 6, 16, 56, 32, 1, 4};

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic configure(input int n, input bit en, input int lim);
        @(negedge clk);
        div_sel  = 4'(n);
        cfg_word = {en, 15'(lim)};
        cfg_wr   = 1'b1;
        @(negedge clk);
        cfg_wr  = 1'b0;
        sts_clr = 1'b1;
        @(negedge clk);
        sts_clr = 1'b0;
    endtask

    // counts edges from now; first = edge index of first pulse, 0 if none
    task automatic measure(input int win, output int first, output int npulse);
        first  = 0;
        npulse = 0;
        for (int e = 1; e <= win; e++) begin
            @(negedge clk);
            if (expire_pulse) begin
                npulse++;
                if (first == 0) first = e;
            end
        end
    endtask

    task automatic drop_hold();
        hold_active = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int first;
        int np;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!expire_pulse, "R1 pulse after reset", int'(expire_pulse), 0);
        chk(!tmo_flag, "R1 flag after reset", int'(tmo_flag), 0);
        // R1 disabled after reset: condition alone does nothing
        hold_active = 1'b1;
        measure(20, first, np);
        chk(np == 0, "R1 reset disabled", np, 0);
        drop_hold();

        // R2 R3 R4 R5 vector table
        for (int i = 0; i < NV; i++) begin
            configure(VN[i], 1'b1, VL[i]);
            hold_active = 1'b1;
            measure(VE[i] + 20, first, np);
            chk(first == VE[i], "R3 first pulse edge", first, VE[i]);
            chk(np == 1, "R5 single pulse", np, 1);
            chk(tmo_flag, "R9 flag after pulse", int'(tmo_flag), 1);
            drop_hold();
        end

        // R10 full range
        configure(0, 1'b1, 32'h7FFF);
        hold_active = 1'b1;
        measure(32767 + 5, first, np);
        chk(first == 32767, "R10 max limit", first, 32767);
        drop_hold();
        configure(15, 1'b1, 1);
        hold_active = 1'b1;
        measure(32768 + 5, first, np);
        chk(first == 32768, "R10 max divider", first, 32768);
        drop_hold();

        // R6 drop before expiry loses progress
        configure(1, 1'b1, 4);
        hold_active = 1'b1;
        measure(7, first, np);
        chk(np == 0, "R6 no pulse before limit", np, 0);
        hold_active = 1'b0;
        @(negedge clk);
        hold_active = 1'b1;
        measure(18, first, np);
        chk(first == 8, "R6 restart after drop", first, 8);
        drop_hold();

        // R7 enable cleared
        configure(0, 1'b0, 2);
        hold_active = 1'b1;
        measure(40, first, np);
        chk(np == 0, "R7 disabled pulses", np, 0);
        chk(!tmo_flag, "R7 disabled flag", int'(tmo_flag), 0);
        drop_hold();

        // R8 rewrite restarts count
        configure(0, 1'b1, 10);
        hold_active = 1'b1;
        measure(6, first, np);
        chk(np == 0, "R8 no early pulse", np, 0);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        measure(20, first, np);
        chk(first == 10, "R8 restart on write", first, 10);
        drop_hold();

        // R9 set beats clear on same edge, holds over drop, clears alone
        configure(0, 1'b1, 3);
        hold_active = 1'b1;
        first = 0;
        for (int e = 1; e <= 10 && first == 0; e++) begin
            @(negedge clk);
            if (expire_pulse) first = e;
        end
        chk(first == 3, "R9 pulse edge", first, 3);
        sts_clr = 1'b1;
        @(negedge clk);
        sts_clr = 1'b0;
        chk(tmo_flag, "R9 set wins over clear", int'(tmo_flag), 1);
        drop_hold();
        chk(tmo_flag, "R9 flag holds after drop", int'(tmo_flag), 1);
        sts_clr = 1'b1;
        @(negedge clk);
        sts_clr = 1'b0;
        chk(!tmo_flag, "R9 clear", int'(tmo_flag), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule